// File: doc/BRIEF.md
# Dual-Mode Word Serializer

This block turns 8b/10b code groups presented on a parallel bus into a serial bit stream. It runs entirely on the bit-rate clock. The reference clock that paces the parallel bus appears as two one-cycle strobes on that clock. `word_stb` marks the reference rising edge and comes once every ten bit cycles. `half_stb` marks the reference falling edge and comes five cycles after `word_stb`.

Two parallel formats are offered. In the wide format the whole 10-bit word is captured at `word_stb`. In the dual-edge format only the five low data lines carry data. The low half-word is taken at `word_stb`, and the high half-word is taken at the following `half_stb`. The two halves are merged into one word only once both are present.

Words reach the shift register only at a word boundary, so a word is never cut short. They leave bit 0 first, one bit per bit-clock cycle. The load-to-last-bit delay is fixed for each format. `ser_oe` marks the cycles in which the serial output carries a real word. While the output is inactive, `ser_out` is held low.

Top module: `dual_mode_serializer`

## Requirements
- R1: Format select `fmt`: the value 0 selects the 10-bit wide format and the value 1 selects the 5-bit dual-edge format. In the wide format no half-word is ever left pending.
- R2: In the wide format, all of `par_data[9:0]` is captured in the bit-clock cycle in which `word_stb` is high.
- R3: In the dual-edge format, word bits 0..4 come from `par_data[4:0]` at `word_stb`, and word bits 5..9 come from `par_data[4:0]` at the next `half_stb`. `par_data[9:5]` has no effect in this format.
- R4: Each word is sent on `ser_out` bit 0 first and bit 9 last, one bit per bit-clock cycle. Consecutive words follow with no gap.
- R5: Let the capturing edge (the edge at which `word_stb` is sampled) be edge 0. Bit 9 of the word is then driven after rising edge 19 in the wide format, and after rising edge 29 in the dual-edge format. `ser_oe` is low before bit 0 of the first word and high from bit 0 on.
- R6: While `rst_n` is low, `ser_oe` and `ser_out` are both 0, starting at once without waiting for a clock edge. Reset release takes effect two bit-clock edges after `rst_n` rises.
- R7: A word enters the output stage only at a `word_stb`, so `ser_oe` can rise only on the cycle after a `word_stb`.
- R8: In the dual-edge format, a `half_stb` with no pending low half-word is ignored. A pending low half-word with no partner is replaced by the next `word_stb` and dropped by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 1 | Format select: 0 wide, 1 dual-edge |
| word_stb | input | 1 | One-cycle pulse at each reference rising edge |
| half_stb | input | 1 | One-cycle pulse at each reference falling edge |
| par_data | input | WORD_W | Parallel code-group input |
| ser_out | output | 1 | Serial bit, bit 0 of each word first |
| ser_oe | output | 1 | High while ser_out carries a word |

## Verification
The bench builds the block with the default word width of ten. With that width, the 19- and 29-cycle latencies and the five-cycle gap between the two strobes take their actual values. Each check can therefore compare a serial bit and the `ser_oe` edge at one exact cycle index counted from the capturing strobe. In the dual-edge runs the unused high data lines are driven with junk, and the data lines carry junk in every cycle that has no strobe. The directed cases pair a strobe with nothing: a lone falling-edge pulse, a low half-word with no high half, and a reset between a low half-word and its partner.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    FMT_WIDE = 1'b0,
    FMT_DUAL = 1'b1
  } fmt_e;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/ser_capture.sv
module ser_capture
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              word_stb,
  input  logic              half_stb,
  input  logic [WORD_W-1:0] par_data,
  output logic [WORD_W-1:0] hold_word,
  output logic              hold_vld,
  output logic              asm_vld,
  output logic              low_pend
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] low_q,   low_d;
  logic              pend_q,  pend_d;
  logic [WORD_W-1:0] asm_q,   asm_d;
  logic              asmv_q,  asmv_d;
  logic [WORD_W-1:0] hold_q,  hold_d;
  logic              holdv_q, holdv_d;
  logic              cap_en;

  assign cap_en = word_stb | half_stb;

  always_comb begin
    low_d   = low_q;
    pend_d  = pend_q;
    asm_d   = asm_q;
    asmv_d  = asmv_q;
    hold_d  = hold_q;
    holdv_d = holdv_q;
    // falling-edge half completes a pending pair
    if (half_stb && pend_q && (fmt == FMT_DUAL)) begin
      asm_d  = {par_data[HALF_W-1:0], low_q};
      asmv_d = 1'b1;
      pend_d = 1'b0;
    end
    // rising edge: commit to hold stage, start a new pair
    if (word_stb) begin
      if (fmt == FMT_WIDE) begin
        hold_d  = par_data;
        holdv_d = 1'b1;
        pend_d  = 1'b0;
      end else begin
        hold_d  = asm_q;
        holdv_d = asmv_q;
        low_d   = par_data[HALF_W-1:0];
        pend_d  = 1'b1;
      end
      asmv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      pend_q  <= 1'b0;
      asm_q   <= '0;
      asmv_q  <= 1'b0;
      hold_q  <= '0;
      holdv_q <= 1'b0;
    end else if (cap_en) begin
      low_q   <= low_d;
      pend_q  <= pend_d;
      asm_q   <= asm_d;
      asmv_q  <= asmv_d;
      hold_q  <= hold_d;
      holdv_q <= holdv_d;
    end
  end

  assign hold_word = hold_q;
  assign hold_vld  = holdv_q;
  assign asm_vld   = asmv_q;
  assign low_pend  = pend_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_vld,
  output logic              ser_bit,
  output logic              ser_oe
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              vld_q, vld_d;

  always_comb begin
    if (load) begin
      sh_d  = load_word;
      vld_d = load_vld;
    end else begin
      sh_d  = {1'b0, sh_q[WORD_W-1:1]};
      vld_d = vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign ser_bit = sh_q[0] & vld_q;
  assign ser_oe  = vld_q;
endmodule

// File: rtl/dual_mode_serializer.sv
module dual_mode_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              fmt,
  input  logic              word_stb,
  input  logic              half_stb,
  input  logic [WORD_W-1:0] par_data,
  output logic              ser_out,
  output logic              ser_oe
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] hold_word;
  logic              hold_vld;
  logic              asm_vld;
  logic              low_pend;
  fmt_e              fmt_sel;

  assign fmt_sel = fmt_e'(fmt);

  ser_rst_sync u_rst (
    .clk     (clk_bit),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  ser_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk_bit),
    .rst_n     (rst_sync_n),
    .fmt       (fmt_sel),
    .word_stb  (word_stb),
    .half_stb  (half_stb),
    .par_data  (par_data),
    .hold_word (hold_word),
    .hold_vld  (hold_vld),
    .asm_vld   (asm_vld),
    .low_pend  (low_pend)
  );

  ser_shift #(.WORD_W(WORD_W)) u_sh (
    .clk       (clk_bit),
    .rst_n     (rst_sync_n),
    .load      (word_stb),
    .load_word (hold_word),
    .load_vld  (hold_vld),
    .ser_bit   (ser_out),
    .ser_oe    (ser_oe)
  );
endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic arst_n,
  input logic fmt,
  input logic word_stb,
  input logic half_stb,
  input logic ser_oe,
  input logic hold_vld,
  input logic asm_vld,
  input logic low_pend
);
  // R6: output inactive whenever external reset is low
  assert_reset_idle_R6: assert property (@(posedge clk)
    !arst_n |-> !ser_oe);

  // R7: output stage becomes active only right after a boundary strobe
  assert_oe_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe) |-> $past(word_stb));

  // R7: hold stage fills only at a boundary strobe
  assert_hold_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_vld) |-> $past(word_stb));

  // R8: an assembled word needs a pending low half and a falling-edge strobe
  assert_pair_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asm_vld) |-> $past(half_stb && low_pend && fmt));

  // R1: wide format leaves no half-word pending
  assert_wide_no_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !fmt) |=> !low_pend);
endmodule

bind dual_mode_serializer ser_tx_chk u_chk (
  .clk      (clk_bit),
  .rst_n    (rst_sync_n),
  .arst_n   (rst_n),
  .fmt      (fmt),
  .word_stb (word_stb),
  .half_stb (half_stb),
  .ser_oe   (ser_oe),
  .hold_vld (hold_vld),
  .asm_vld  (asm_vld),
  .low_pend (low_pend)
);

// File: tb/dual_mode_serializer_tb_top.sv
`timescale 1ns/1ps
module dual_mode_serializer_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fmt = 1'b0;
  logic         word_stb = 1'b0;
  logic         half_stb = 1'b0;
  logic [W-1:0] par_data = '0;
  logic         ser_out;
  logic         ser_oe;

  int errors = 0;
  int checks = 0;
  int ecnt = 0;
  logic obs_b [0:4095];
  logic obs_e [0:4095];

  // {latency[4:0], fmt, word[9:0]}
  localparam logic [15:0] VEC [8] = '{
    {5'd19, 1'b0, 10'h17C}, {5'd19, 1'b0, 10'h283},
    {5'd19, 1'b0, 10'h001}, {5'd19, 1'b0, 10'h200},
    {5'd29, 1'b1, 10'h17C}, {5'd29, 1'b1, 10'h3FF},
    {5'd29, 1'b1, 10'h2AA}, {5'd29, 1'b1, 10'h01F}
  };

  dual_mode_serializer #(.WORD_W(W)) dut_i (
    .clk_bit(clk), .rst_n(rst_n), .fmt(fmt), .word_stb(word_stb),
    .half_stb(half_stb), .par_data(par_data), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) ecnt <= ecnt + 1;

  always @(negedge clk) begin
    obs_b[ecnt % 4096] = ser_out;
    obs_e[ecnt % 4096] = ser_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    word_stb = 1'b0;
    half_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [W-1:0] word_of(input logic [W-1:0] w0, input int p);
    if (p == 0) return w0;
    if (p == 1) return ~w0;
    return w0 ^ 10'h155;
  endfunction

  // Drives nwords periods; returns the index of the first capturing edge.
  task automatic run_stream(input logic m, input logic [W-1:0] w0, input int nwords,
                            output int s);
    logic [W-1:0] w;
    @(negedge clk);
    s = ecnt + 1;
    fmt = m;
    for (int p = 0; p < nwords; p++) begin
      w = word_of(w0, p);
      for (int c = 0; c < 10; c++) begin
        if (c != 0 || p != 0) @(negedge clk);
        word_stb = (c == 0);
        half_stb = m && (c == 5);
        if (c == 0)      par_data = m ? {~w[4:0], w[4:0]} : w;
        else if (c == 5) par_data = {w[4:0] ^ 5'h0B, w[9:5]};
        else             par_data = ~w ^ W'(c);
      end
    end
    @(negedge clk);
    word_stb = 1'b0;
    half_stb = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic check_word(input int b0, input logic [W-1:0] w, input string req);
    logic [W-1:0] got;
    logic         oe_all;
    oe_all = 1'b1;
    for (int i = 0; i < W; i++) begin
      got[i] = obs_b[(b0 + i) % 4096];
      oe_all &= obs_e[(b0 + i) % 4096];
    end
    chk(got == w, req, got, w);
    chk(oe_all, {req, " oe"}, oe_all, 1);
  endtask

  initial begin
    int s;
    int lat;
    logic m;
    logic [W-1:0] w;

    // R6: reset state, asynchronous
    #1;
    chk(ser_oe == 1'b0 && ser_out == 1'b0, "R6 reset state", {ser_oe, ser_out}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ser_oe == 1'b0, "R6 idle after release", ser_oe, 0);

    // Table: R1 R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      lat = int'(VEC[k][15:11]);
      m   = VEC[k][10];
      w   = VEC[k][9:0];
      do_reset();
      run_stream(m, w, 4, s);
      chk(obs_e[(s + lat - 10) % 4096] == 1'b0, "R5 oe low before bit0",
          obs_e[(s + lat - 10) % 4096], 0);
      check_word(s + lat - 9, w, m ? "R3 R4 R5 dual word0" : "R2 R4 R5 wide word0");
      check_word(s + lat + 1, ~w, m ? "R1 R4 dual word1" : "R1 R4 wide word1");
    end

    // R6: asynchronous reset while active
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(ser_oe == 1'b0 && ser_out == 1'b0, "R6 async drop", {ser_oe, ser_out}, 0);

    // R8: lone low half dropped by reset, lone falling strobe ignored
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fmt = 1'b1;
    word_stb = 1'b1; par_data = 10'h00A;
    @(negedge clk);
    word_stb = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    half_stb = 1'b1; par_data = 10'h01F;
    @(negedge clk);
    half_stb = 1'b0;
    repeat (3) @(negedge clk);
    run_stream(1'b1, 10'h0C3, 4, s);
    chk(obs_e[(s + 10) % 4096] == 1'b0, "R8 orphan halves discarded",
        obs_e[(s + 10) % 4096], 0);
    chk(obs_e[(s + 19) % 4096] == 1'b0, "R8 R5 oe low before bit0",
        obs_e[(s + 19) % 4096], 0);
    check_word(s + 20, 10'h0C3, "R8 first word after orphans");

    // R8: low half with no partner replaced by the next one
    do_reset();
    fmt = 1'b1;
    word_stb = 1'b1; par_data = 10'h015;
    for (int c = 1; c < 10; c++) begin
      @(negedge clk);
      word_stb = 1'b0;
      par_data = 10'h3E0 | W'(c);
    end
    run_stream(1'b1, 10'h2D2, 4, s);
    chk(obs_e[(s + 19) % 4096] == 1'b0, "R8 unpaired half no word",
        obs_e[(s + 19) % 4096], 0);
    check_word(s + 20, 10'h2D2, "R8 replaced low half");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule